// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block couples a small processor to an on-chip byte-wide data EEPROM. Software sees three registers behind a two-bit register select: a location register, a byte register and a command/status register. Setting the read command bit fetches the byte at the stored location into the byte register at once, then holds the processor in a stall for a fixed number of clocks. Setting the write command bit copies the location and byte into a private write engine. The engine times the program operation by counting pulses from a calibrated oscillator, not processor clocks.

While the engine is busy, read commands and changes to the location register are refused. No write may start while a flash self-program operation reports busy. A system reset that arrives during a write leaves the write engine running until the write commits. Only a power-on reset clears the engine unconditionally. The array itself is outside the block: its read port is combinational and its write port takes one byte on a clock edge while the write strobe is high.

Top module: `eeprom_ctrl`

## Requirements
- R1: After a power-on or system reset with no write in progress, the location register (select 0), the byte register (select 1) and the command/status register (select 2) all read 0, and `cpu_stall` is low. Select 3 always reads 0.
- R2: Writing select 2 with bit 0 set while not busy loads the byte register with the array byte at the location register. The new value is readable from the next cycle.
- R3: An accepted read drives `cpu_stall` high for exactly STALL_CYCLES (default 4) consecutive cycles, starting the cycle after the command.
- R4: Command bits 0 (read) and 1 (write) of select 2 always read back as 0.
- R5: Writing select 2 with bit 1 set, while not busy and with `spm_busy` low, starts a write of the byte register to the location register. Busy (bit 2 of select 2) reads 1 from the next cycle.
- R6: A write commits to the array on the clock edge of the WR_TICKS-th (default 4) `osc_tick` pulse after the start. Busy clears on that same edge. Before that edge the array location is unchanged.
- R7: While busy, a read command is ignored (no stall, byte register unchanged) and writes to the location register are discarded.
- R8: A write command given while `spm_busy` is high is ignored: busy stays 0 and the array is not written.
- R9: A system reset (`rst_n` low) during a write does not abort it. Busy stays 1 and the write commits after its remaining ticks, while the registers are cleared. `por_n` clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| rst_n | input | 1 | System reset, active low, synchronous, spares a running write |
| reg_sel | input | 2 | Register select: 0 location, 1 byte, 2 command/status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read-back of the selected register |
| cpu_stall | output | 1 | Holds the processor after a read |
| osc_tick | input | 1 | One-cycle pulse from the calibrated oscillator |
| spm_busy | input | 1 | Flash self-program operation in progress |
| mem_addr | output | AW | Array address (write engine's address while busy) |
| mem_rdata | input | DW | Array read data, combinational from mem_addr |
| mem_we | output | 1 | Array write strobe, one cycle |
| mem_wdata | output | DW | Array write data |

## Verification
Reads are tried at fixed and random locations, with the array preset from a computed pattern. Comparing each byte tells apart a correct fetch from a wrong address or a stale register. Writes of random bytes are followed by reads of the same and of other locations. Tick pulses are issued one at a time, so a commit one tick early or late shows up. Directed cases overlap a busy write with a read command, a location change and a system reset, and raise `spm_busy` during a write command. Each of these separates a refused access from one that slipped through.

// File: rtl/eec_pkg.sv
package eec_pkg;
   typedef enum logic [1:0] {
      SEL_LOC  = 2'd0,
      SEL_BYTE = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int CMD_RD_BIT   = 0;
   localparam int CMD_WR_BIT   = 1;
   localparam int CMD_BUSY_BIT = 2;
endpackage

// File: rtl/eec_stall_timer.sv
module eec_stall_timer #(
   parameter int STALL_CYCLES = 4
) (
   input  logic clk,
   input  logic clr,
   input  logic start,
   output logic stall_o
);
   localparam int CW = (STALL_CYCLES < 1) ? 1 : $clog2(STALL_CYCLES + 1);

   initial assert (STALL_CYCLES >= 0) else $error("STALL_CYCLES must not be negative");

   generate
      if (STALL_CYCLES == 0) begin : g_no_stall
         assign stall_o = 1'b0;
      end else begin : g_stall
         logic [CW-1:0] left_q;
         logic [CW:0]   run_q;

         always_ff @(posedge clk) begin
            if (clr)
               left_q <= '0;
            else if (start)
               left_q <= CW'(STALL_CYCLES);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end

         assign stall_o = (left_q != '0);

         // checker: length of each stall window
         always_ff @(posedge clk) begin
            if (clr)
               run_q <= '0;
            else if (stall_o)
               run_q <= run_q + 1'b1;
            else
               run_q <= '0;
         end

         assert_stall_len_R3: assert property (@(posedge clk) disable iff (clr)
            $fell(stall_o) |-> (run_q == (CW+1)'(STALL_CYCLES)));
      end
   endgenerate
endmodule

// File: rtl/eec_write_seq.sv
module eec_write_seq #(
   parameter int AW       = 6,
   parameter int DW       = 8,
   parameter int WR_TICKS = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          spm_busy,
   input  logic          tick,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          busy_o,
   output logic          mem_we,
   output logic [AW-1:0] waddr_o,
   output logic [DW-1:0] wdata_o
);
   localparam int TW = $clog2(WR_TICKS + 1);

   initial assert (WR_TICKS >= 1) else $error("WR_TICKS must be at least 1");

   logic          busy_q;
   logic [TW-1:0] cnt_q;
   logic          last_tick;
   logic          accept;

   assign accept    = start_req && !busy_q && !spm_busy;
   assign last_tick = busy_q && tick && (cnt_q == TW'(WR_TICKS - 1));

   // a system reset only clears the engine when no write is running
   always_ff @(posedge clk) begin
      if (!por_n || (!rst_n && !busy_q)) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         waddr_o <= '0;
         wdata_o <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         cnt_q   <= '0;
         waddr_o <= addr_in;
         wdata_o <= data_in;
      end else if (last_tick) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign mem_we = last_tick;

   assert_no_spm_start_R8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy_q) |-> $past(!spm_busy));

   assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!por_n)
      mem_we |=> !busy_q);

   assert_busy_survives_R9: assert property (@(posedge clk) disable iff (!por_n)
      (busy_q && !mem_we) |=> busy_q);
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
   import eec_pkg::*;
#(
   parameter int AW           = 6,
   parameter int DW           = 8,
   parameter int STALL_CYCLES = 4,
   parameter int WR_TICKS     = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic [1:0]    reg_sel,
   input  logic          reg_we,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          cpu_stall,
   input  logic          osc_tick,
   input  logic          spm_busy,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata
);
   initial assert (AW >= 1 && AW <= DW) else $error("AW must lie in 1..DW");
   initial assert (DW > CMD_BUSY_BIT) else $error("DW too narrow for command bits");

   reg_sel_e      sel;
   logic          any_rst;
   logic          busy;
   logic          cmd_wr;
   logic          rd_go;
   logic          wr_req;
   logic [AW-1:0] loc_q;
   logic [DW-1:0] byte_q;
   logic [AW-1:0] eng_addr;

   assign sel     = reg_sel_e'(reg_sel);
   assign any_rst = !por_n || !rst_n;
   assign cmd_wr  = reg_we && (sel == SEL_CMD);
   assign rd_go   = cmd_wr && reg_wdata[CMD_RD_BIT] && !busy;
   assign wr_req  = cmd_wr && reg_wdata[CMD_WR_BIT] && rst_n;

   always_ff @(posedge clk) begin
      if (any_rst) begin
         loc_q  <= '0;
         byte_q <= '0;
      end else begin
         if (reg_we && sel == SEL_LOC && !busy)
            loc_q <= reg_wdata[AW-1:0];
         if (reg_we && sel == SEL_BYTE)
            byte_q <= reg_wdata;
         else if (rd_go)
            byte_q <= mem_rdata;
      end
   end

   eec_write_seq #(
      .AW(AW), .DW(DW), .WR_TICKS(WR_TICKS)
   ) u_wseq (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .start_req(wr_req), .spm_busy(spm_busy), .tick(osc_tick),
      .addr_in(loc_q), .data_in(byte_q),
      .busy_o(busy), .mem_we(mem_we),
      .waddr_o(eng_addr), .wdata_o(mem_wdata)
   );

   eec_stall_timer #(
      .STALL_CYCLES(STALL_CYCLES)
   ) u_stall (
      .clk(clk), .clr(any_rst), .start(rd_go), .stall_o(cpu_stall)
   );

   assign mem_addr = busy ? eng_addr : loc_q;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_LOC:  reg_rdata = DW'(loc_q);
         SEL_BYTE: reg_rdata = byte_q;
         SEL_CMD:  reg_rdata[CMD_BUSY_BIT] = busy;
         default:  reg_rdata = '0;
      endcase
   end

   generate
      if (STALL_CYCLES > 0) begin : g_stall_chk
         assert_stall_follows_read_R3: assert property (@(posedge clk) disable iff (any_rst)
            rd_go |=> cpu_stall);
      end
   endgenerate

   assert_loc_frozen_R7: assert property (@(posedge clk) disable iff (any_rst)
      (busy && $past(busy) && $past(rst_n) && $past(por_n)) |-> $stable(loc_q));
endmodule

// File: tb/eeprom_ctrl_tb.sv
module eeprom_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int NLOC = 1 << AW;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    reg_sel = 2'd3;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          cpu_stall;
   logic          osc_tick = 1'b0;
   logic          spm_busy = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;

   logic [DW-1:0] arr [NLOC];
   logic [DW-1:0] shadow [NLOC];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_ctrl u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_stall(cpu_stall), .osc_tick(osc_tick), .spm_busy(spm_busy),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   assign mem_rdata = arr[mem_addr];
   always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

   function automatic logic [DW-1:0] seed_byte(int i);
      return DW'(i * 29) ^ 8'h5A;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(logic [1:0] s, logic [DW-1:0] v);
      @(negedge clk);
      reg_sel = s; reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(logic [1:0] s, output logic [DW-1:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end
   endtask

   task automatic do_read(logic [AW-1:0] a);
      logic [DW-1:0] v;
      int n;
      wr_reg(2'd0, DW'(a));
      wr_reg(2'd2, 8'h01);
      n = 0;
      while (cpu_stall && n < 10) begin n++; @(negedge clk); end
      check(n == 4, "R3 stall length", n, 4);
      rd_reg(2'd1, v);
      check(v == shadow[a], "R2 read byte", v, shadow[a]);
      rd_reg(2'd2, v);
      check(v == 8'h00, "R4 command bits read zero", v, 0);
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
      logic [DW-1:0] v;
      wr_reg(2'd0, DW'(a));
      wr_reg(2'd1, d);
      wr_reg(2'd2, 8'h02);
      rd_reg(2'd2, v);
      check(v == 8'h04, "R5 busy after start", v, 4);
      ticks(3);
      rd_reg(2'd2, v);
      check(v == 8'h04, "R6 busy before last tick", v, 4);
      check(arr[a] == shadow[a], "R6 array untouched early", arr[a], shadow[a]);
      ticks(1);
      rd_reg(2'd2, v);
      check(v == 8'h00, "R6 busy cleared", v, 0);
      check(arr[a] == d, "R6 array written", arr[a], d);
      shadow[a] = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      logic [AW-1:0] a, b;
      logic [DW-1:0] d;
      void'($urandom(32'd4242));
      for (int i = 0; i < NLOC; i++) begin arr[i] = seed_byte(i); shadow[i] = seed_byte(i); end

      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_reg(2'd0, v); check(v == 0, "R1 location reset", v, 0);
      rd_reg(2'd1, v); check(v == 0, "R1 byte reset", v, 0);
      rd_reg(2'd2, v); check(v == 0, "R1 command reset", v, 0);
      rd_reg(2'd3, v); check(v == 0, "R1 select 3 zero", v, 0);
      check(cpu_stall == 0, "R1 stall low", cpu_stall, 0);

      // directed reads at the ends of the space
      do_read(6'd0);
      do_read(6'd63);
      // directed write then read
      do_write(6'd17, 8'hC3);
      do_read(6'd17);

      // R7: read and location change refused while busy
      wr_reg(2'd0, 8'd5);
      wr_reg(2'd1, 8'h3C);
      wr_reg(2'd2, 8'h02);
      wr_reg(2'd0, 8'd40);
      wr_reg(2'd2, 8'h01);
      check(cpu_stall == 0, "R7 no stall while busy", cpu_stall, 0);
      rd_reg(2'd1, v); check(v == 8'h3C, "R7 byte unchanged while busy", v, 8'h3C);
      rd_reg(2'd0, v); check(v == 8'd5, "R7 location write discarded", v, 5);
      ticks(4);
      check(arr[5] == 8'h3C, "R7 write still lands", arr[5], 8'h3C);
      shadow[5] = 8'h3C;

      // R8: write refused while flash self-program busy
      spm_busy = 1'b1;
      wr_reg(2'd0, 8'd9);
      wr_reg(2'd1, 8'hAA);
      wr_reg(2'd2, 8'h02);
      rd_reg(2'd2, v); check(v == 8'h00, "R8 no busy under spm", v, 0);
      ticks(5);
      check(arr[9] == shadow[9], "R8 array not written", arr[9], shadow[9]);
      spm_busy = 1'b0;

      // R9: system reset during a write
      wr_reg(2'd0, 8'd33);
      wr_reg(2'd1, 8'h77);
      wr_reg(2'd2, 8'h02);
      ticks(2);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      rd_reg(2'd2, v); check(v == 8'h04, "R9 busy kept over reset", v, 4);
      rd_reg(2'd0, v); check(v == 0, "R9 location cleared", v, 0);
      ticks(2);
      rd_reg(2'd2, v); check(v == 8'h00, "R9 busy cleared after commit", v, 0);
      check(arr[33] == 8'h77, "R9 write completed", arr[33], 8'h77);
      shadow[33] = 8'h77;

      // random mix of writes and reads
      for (int k = 0; k < 30; k++) begin
         a = AW'($urandom_range(0, NLOC - 1));
         b = AW'($urandom_range(0, NLOC - 1));
         d = DW'($urandom);
         do_write(a, d);
         do_read(a);
         do_read(b);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule